// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an asynchronous static RAM of 256K bytes. It turns one-word read and write requests into the pin-level control sequence that the RAM needs. The host offers a request with a direction flag, an 18-bit address and a write byte. The controller accepts the request when it is ready, drops ready while the memory cycle runs, and raises a one-clock valid strobe when the read byte is captured.

On the memory side it drives an active-low select, an active-high select, an active-low write strobe, an active-low output-enable, the address and a data bus. The data bus is split into an outgoing byte, an incoming byte and a drive flag, so that a pad ring can build the tri-state buffer. Every timing window is a count of clock cycles. Each count is derived from a nanosecond parameter and the clock period, and is rounded up. The defaults match a 70 ns RAM on a 4 ns clock.

Write cycles wait until the RAM has had time to release the shared bus after a read. Every operation ends with a turnaround interval in which all drivers are released.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and after its release, host_ready is 1, host_rvalid is 0, sram_cs_n is 1, sram_cs is 0, sram_we_n is 1, sram_oe_n is 1 and sram_dq_oe is 0.
- R2: A request is taken at a rising clock edge where host_req and host_ready are both 1 (host_we 1 = write, 0 = read). host_ready is 0 from the next cycle until the operation and its turnaround have finished.
- R3: A write holds sram_cs_n at 0, sram_cs at 1 and sram_we_n at 0 for max(ceil(55/T), ceil(30/T), ceil(60/T)) consecutive cycles, which is 15 at T = 4 ns. Address and data stay stable throughout, and the RAM stores the byte.
- R4: After the write strobe rises, the data stays driven with the selects released for max(ceil(70/T) - write pulse, 1) cycles, so that the whole write cycle is at least ceil(70/T) cycles.
- R5: A read holds both selects active and sram_oe_n at 0 for max(ceil(70/T), ceil(35/T)) cycles, which is 18. sram_dq_i is sampled at the last of these edges, and host_rvalid is a single-cycle pulse in the cycle that follows.
- R6: sram_dq_oe is never 1 while sram_oe_n is 0. sram_we_n is 0 only while both selects are active and sram_oe_n is 1.
- R7: sram_dq_oe rises only after sram_oe_n has been 1 for at least ceil(25/T) = 7 cycles. A write that follows a read waits for this.
- R8: Before host_ready returns to 1, at least one full cycle passes with both selects inactive, sram_we_n and sram_oe_n at 1, and sram_dq_oe at 0.
- R9: Host inputs that change while host_ready is 0 have no effect: sram_addr and the write byte stay at the accepted values, and no second operation is started.
- R10: host_rdata holds the last captured byte until the next read completes. A write does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Operation request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte address |
| host_wdata | input | DATA_W | Byte to write |
| host_ready | output | 1 | Controller idle, request can be taken |
| host_rdata | output | DATA_W | Last byte read |
| host_rvalid | output | 1 | One-cycle pulse when host_rdata is updated |
| sram_cs_n | output | 1 | Active-low chip select |
| sram_cs | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_addr | output | ADDR_W | Memory address |
| sram_dq_o | output | DATA_W | Outgoing data byte |
| sram_dq_oe | output | 1 | Drive enable for the data bus |
| sram_dq_i | input | DATA_W | Incoming data byte |

## Verification
The two functions that can meet in one cycle are the acceptance of a write request and the bus-release wait that follows a read. When a write arrives straight after a read, the RAM may still be driving the bus. The controller must hold off its own driver even though the write has already been taken. The bench provokes this by issuing reads and writes back to back, in directed pairs and in a random mix over a small address pool. A bus model in the bench keeps driving for the release time after output-enable rises. It flags any overlap with the controller's drive flag and counts the high cycles of output-enable before the drive begins.

// File: rtl/asc_pkg.sv
package asc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WWAIT  = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WHOLD  = 3'd4,
    ST_TURN   = 3'd5
  } asc_state_e;

  typedef struct packed {
    logic sel_n;
    logic sel;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } asc_pins_t;

  localparam asc_pins_t PINS_IDLE = '{sel_n: 1'b1, sel: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

  // Nanoseconds to clock cycles, rounded up, never below one.
  function automatic int ns_to_cyc(input int t_ns, input int clk_ps);
    int c;
    c = (t_ns * 1000 + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asc_interval_ctr.sv
module asc_interval_ctr #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // R5/R3: a running window shrinks by exactly one per cycle
  a_r5_window_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/asc_release_guard.sv
module asc_release_guard #(
  parameter int N_HZ  = 7,
  parameter int CNT_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_drive,
  output logic quiet
);

  localparam logic [CNT_W-1:0] HZ_LIM = CNT_W'(N_HZ);

  logic [CNT_W-1:0] gap_q;
  logic [CNT_W-1:0] gap_d;
  logic             gap_en;

  always_comb begin
    gap_en = dev_drive || (gap_q != HZ_LIM);
    gap_d  = dev_drive ? '0 : gap_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= HZ_LIM;
    else if (gap_en) gap_q <= gap_d;
  end

  assign quiet = (gap_q == HZ_LIM);

  // R7: the memory driving the bus always clears the quiet flag
  a_r7_drive_clears_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    dev_drive |=> !quiet);

endmodule

// File: rtl/asc_fsm.sv
module asc_fsm
  import asc_pkg::*;
#(
  parameter int N_RD   = 18,
  parameter int N_WR   = 15,
  parameter int N_WREC = 3,
  parameter int N_TURN = 1,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_we,
  input  logic             quiet,
  input  logic             cnt_done,
  output asc_state_e       state_q,
  output asc_state_e       state_d,
  output logic             accept,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val
);

  localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] LD_WR   = CNT_W'(N_WR - 1);
  localparam logic [CNT_W-1:0] LD_WREC = CNT_W'(N_WREC - 1);
  localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(N_TURN - 1);

  always_comb begin
    state_d  = state_q;
    accept   = 1'b0;
    cnt_load = 1'b0;
    cnt_val  = '0;
    case (state_q)
      ST_IDLE: begin
        if (req) begin
          accept = 1'b1;
          if (!req_we) begin
            state_d  = ST_READ;
            cnt_load = 1'b1;
            cnt_val  = LD_RD;
          end else if (quiet) begin
            state_d  = ST_WPULSE;
            cnt_load = 1'b1;
            cnt_val  = LD_WR;
          end else begin
            state_d  = ST_WWAIT;
          end
        end
      end
      ST_WWAIT: begin
        if (quiet) begin
          state_d  = ST_WPULSE;
          cnt_load = 1'b1;
          cnt_val  = LD_WR;
        end
      end
      ST_WPULSE: begin
        if (cnt_done) begin
          state_d  = ST_WHOLD;
          cnt_load = 1'b1;
          cnt_val  = LD_WREC;
        end
      end
      ST_WHOLD, ST_READ: begin
        if (cnt_done) begin
          state_d  = ST_TURN;
          cnt_load = 1'b1;
          cnt_val  = LD_TURN;
        end
      end
      ST_TURN: begin
        if (cnt_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R8: the idle state is only ever reached through the turnaround state
  a_r8_turn_precedes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && $past(state_q) != ST_IDLE) |-> ($past(state_q) == ST_TURN));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import asc_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 8,
  parameter int CLK_PS   = 4000,
  parameter int T_WC_NS  = 70,
  parameter int T_WP_NS  = 55,
  parameter int T_DW_NS  = 30,
  parameter int T_AW_NS  = 60,
  parameter int T_CW_NS  = 60,
  parameter int T_RC_NS  = 70,
  parameter int T_AA_NS  = 70,
  parameter int T_OE_NS  = 35,
  parameter int T_HZ_NS  = 25,
  parameter int TURN_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              sram_cs_n,
  output logic              sram_cs,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int N_WP   = ns_to_cyc(T_WP_NS, CLK_PS);
  localparam int N_WC   = ns_to_cyc(T_WC_NS, CLK_PS);
  localparam int N_DW   = ns_to_cyc(T_DW_NS, CLK_PS);
  localparam int N_AW   = ns_to_cyc(T_AW_NS, CLK_PS);
  localparam int N_CW   = ns_to_cyc(T_CW_NS, CLK_PS);
  localparam int N_RC   = ns_to_cyc(T_RC_NS, CLK_PS);
  localparam int N_AA   = ns_to_cyc(T_AA_NS, CLK_PS);
  localparam int N_OE   = ns_to_cyc(T_OE_NS, CLK_PS);
  localparam int N_HZ   = ns_to_cyc(T_HZ_NS, CLK_PS);
  localparam int N_WR   = max2(max2(N_WP, N_DW), max2(N_AW, N_CW));
  localparam int N_WREC = max2(N_WC - N_WR, 1);
  localparam int N_RD   = max2(max2(N_RC, N_AA), N_OE);
  localparam int N_TURN = max2(TURN_CYC, 1);
  localparam int N_MAX  = max2(max2(N_RD, N_WR), max2(max2(N_WREC, N_TURN), N_HZ));
  localparam int CNT_W  = $clog2(N_MAX + 2);

  // Reset: asserted at once, released on the clock
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  asc_state_e       state_q;
  asc_state_e       state_d;
  logic             accept;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_done;
  logic             quiet;
  asc_pins_t        pins_q;
  asc_pins_t        pins_d;
  logic             dev_drive;

  assign dev_drive = !pins_q.sel_n && pins_q.sel && !pins_q.oe_n && pins_q.we_n;

  asc_fsm #(
    .N_RD   (N_RD),
    .N_WR   (N_WR),
    .N_WREC (N_WREC),
    .N_TURN (N_TURN),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req      (host_req),
    .req_we   (host_we),
    .quiet    (quiet),
    .cnt_done (cnt_done),
    .state_q  (state_q),
    .state_d  (state_d),
    .accept   (accept),
    .cnt_load (cnt_load),
    .cnt_val  (cnt_val)
  );

  asc_interval_ctr #(
    .CNT_W (CNT_W)
  ) u_window (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .done     (cnt_done)
  );

  asc_release_guard #(
    .N_HZ  (N_HZ),
    .CNT_W (CNT_W)
  ) u_guard (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .dev_drive (dev_drive),
    .quiet     (quiet)
  );

  // Pin values follow the next state, so every pin leaves a flop
  always_comb begin
    pins_d = PINS_IDLE;
    case (state_d)
      ST_READ: begin
        pins_d.sel_n = 1'b0;
        pins_d.sel   = 1'b1;
        pins_d.oe_n  = 1'b0;
      end
      ST_WPULSE: begin
        pins_d.sel_n = 1'b0;
        pins_d.sel   = 1'b1;
        pins_d.we_n  = 1'b0;
        pins_d.dq_oe = 1'b1;
      end
      ST_WHOLD: begin
        pins_d.dq_oe = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pins_q <= PINS_IDLE;
    else             pins_q <= pins_d;
  end

  // Request fields, loaded only when a request is taken
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= host_addr;
      wdata_q <= host_wdata;
    end
  end

  // Read capture at the last edge of the access window
  logic              rd_capture;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  assign rd_capture = (state_q == ST_READ) && cnt_done;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)     rdata_q <= '0;
    else if (rd_capture) rdata_q <= sram_dq_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rvalid_q <= 1'b0;
    else             rvalid_q <= rd_capture;
  end

  assign host_ready  = (state_q == ST_IDLE);
  assign host_rdata  = rdata_q;
  assign host_rvalid = rvalid_q;
  assign sram_cs_n   = pins_q.sel_n;
  assign sram_cs     = pins_q.sel;
  assign sram_we_n   = pins_q.we_n;
  assign sram_oe_n   = pins_q.oe_n;
  assign sram_dq_oe  = pins_q.dq_oe;
  assign sram_addr   = addr_q;
  assign sram_dq_o   = wdata_q;

  // ---------------- assertion support counters ----------------
  localparam logic [CNT_W-1:0] HZ_SAT = CNT_W'(N_HZ);

  logic [CNT_W-1:0] we_lo_cnt;
  logic [CNT_W-1:0] oe_hi_cnt;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)           we_lo_cnt <= '0;
    else if (sram_we_n)        we_lo_cnt <= '0;
    else if (we_lo_cnt != '1)  we_lo_cnt <= we_lo_cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)             oe_hi_cnt <= HZ_SAT;
    else if (!sram_oe_n)         oe_hi_cnt <= '0;
    else if (oe_hi_cnt < HZ_SAT) oe_hi_cnt <= oe_hi_cnt + CNT_W'(1);
  end

  // R6: no controller drive while the memory output is enabled
  a_r6_no_drive_with_oe: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sram_dq_oe |-> sram_oe_n);

  // R6: write strobe only under both selects with outputs disabled
  a_r6_we_gated: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sram_we_n |-> (!sram_cs_n && sram_cs && sram_oe_n));

  // R3: write strobe pulse is never shorter than the write-pulse minimum
  a_r3_we_width: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(sram_we_n) |-> (we_lo_cnt >= CNT_W'(N_WP)));

  // R7: data drive starts only after output enable has been high long enough
  a_r7_release_gap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(sram_dq_oe) |-> (oe_hi_cnt >= HZ_SAT));

  // R5: read valid is a single-cycle pulse
  a_r5_rvalid_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_rvalid |=> !host_rvalid);

  // R5: read valid follows a cycle with the memory output enabled
  a_r5_rvalid_after_oe: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_rvalid |-> $past(!sram_oe_n && !sram_cs_n));

  // R8: an idle controller releases every memory pin
  a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_ready |-> (sram_cs_n && !sram_cs && sram_we_n && sram_oe_n && !sram_dq_oe));

  // R9: the address stays fixed while an operation runs
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!host_ready && $past(!host_ready)) |-> $stable(sram_addr));

endmodule

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;

  localparam int CLK_PS = 4000;

  function automatic int cdiv(input int ns);
    return (ns * 1000 + CLK_PS - 1) / CLK_PS;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_WP = cdiv(55);
  localparam int E_DW = cdiv(30);
  localparam int E_AW = cdiv(60);
  localparam int E_WC = cdiv(70);
  localparam int E_AA = cdiv(70);
  localparam int E_HZ = cdiv(25);
  localparam int E_RD = imax(imax(cdiv(70), E_AA), cdiv(35));
  localparam int E_TURN = 1;

  logic        clk;
  logic        rst_n;
  logic        req;
  logic        we;
  logic [17:0] addr;
  logic [7:0]  wdata;
  logic        ready;
  logic [7:0]  rdata;
  logic        rvalid;
  logic        cs_n;
  logic        cs;
  logic        we_n;
  logic        oe_n;
  logic [17:0] maddr;
  logic [7:0]  dq_o;
  logic        dq_oe;
  logic [7:0]  dq_i;

  sram_async_ctrl u_sram_async_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_req    (req),
    .host_we     (we),
    .host_addr   (addr),
    .host_wdata  (wdata),
    .host_ready  (ready),
    .host_rdata  (rdata),
    .host_rvalid (rvalid),
    .sram_cs_n   (cs_n),
    .sram_cs     (cs),
    .sram_we_n   (we_n),
    .sram_oe_n   (oe_n),
    .sram_addr   (maddr),
    .sram_dq_o   (dq_o),
    .sram_dq_oe  (dq_oe),
    .sram_dq_i   (dq_i)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] mem    [int];
  logic [7:0] shadow [int];

  function automatic logic [7:0] mem_rd(input logic [17:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [17:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
  endfunction

  int          rd_cnt;
  int          tail;
  int          wcnt;
  int          dst;
  int          ast;
  int          oe_hi;
  bit          wr_prev;
  bit          oe_bad;
  bit          dq_oe_prev;
  bit          ready_prev;
  bit          rel_prev;
  logic [7:0]  wd_last;
  logic [17:0] wa_last;

  always @(negedge clk) begin
    bit sel;
    bit drv;
    bit wr;
    bit rel;
    if (!rst_n) begin
      rd_cnt = 0; tail = 0; wcnt = 0; dst = 0; ast = 0; oe_hi = 100;
      wr_prev = 0; oe_bad = 0; dq_oe_prev = 0; ready_prev = 1; rel_prev = 1;
      dq_i = 8'hEE;
    end else begin
      sel = !cs_n && cs;
      drv = sel && !oe_n && we_n;
      // R6 R7: memory still driving (enabled or within release time)
      if (dq_oe) check(!(drv || tail > 0), "R7 bus contention", int'(tail), 0);
      oe_hi = oe_n ? oe_hi + 1 : 0;
      if (dq_oe && !dq_oe_prev) check(oe_hi >= E_HZ, "R7 release gap", oe_hi, E_HZ);
      if (drv) begin
        rd_cnt++;
        tail = E_HZ - 1;
        dq_i = (rd_cnt >= E_AA) ? mem_rd(maddr) : 8'hEE;
      end else begin
        if (tail > 0) tail--;
        rd_cnt = 0;
        dq_i = 8'hEE;
      end
      wr = sel && !we_n;
      if (wr) begin
        wcnt++;
        if (dq_oe && wcnt > 1 && dq_o == wd_last) dst++; else dst = dq_oe ? 1 : 0;
        if (wcnt > 1 && maddr == wa_last) ast++; else ast = 1;
        wd_last = dq_o;
        wa_last = maddr;
        if (!oe_n) oe_bad = 1;
      end else if (wr_prev) begin
        check(wcnt >= E_WP, "R3 pulse width", wcnt, E_WP);
        check(dst >= E_DW, "R3 data setup", dst, E_DW);
        check(ast >= E_AW, "R3 address setup", ast, E_AW);
        check(!oe_bad, "R6 oe during write", int'(oe_bad), 0);
        mem[int'(wa_last)] = wd_last;
        wcnt = 0; oe_bad = 0;
      end
      wr_prev = wr;
      rel = cs_n && !cs && we_n && oe_n && !dq_oe;
      if (ready && !ready_prev) check(rel_prev, "R8 turnaround", int'(rel_prev), 1);
      dq_oe_prev = dq_oe;
      ready_prev = ready;
      rel_prev   = rel;
    end
  end

  // ---------------- host side ----------------
  logic [7:0] last_rd = 8'h00;

  task automatic do_op(input bit w, input logic [17:0] a, input logic [7:0] d);
    int  busy;
    bit  got;
    logic [7:0] exp_v;
    @(negedge clk);
    while (!ready) @(negedge clk);
    exp_v = exp_rd(a);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    check(!ready, "R2 ready drop", int'(ready), 0);
    // R9: fields scrambled with request held high while busy
    addr = 18'($urandom); wdata = 8'($urandom); we = 1'($urandom);
    busy = 1; got = 0;
    while (!ready && busy < 1000) begin
      if (rvalid) begin
        check(!w, "R5 rvalid on write", int'(w), 0);
        check(busy == E_RD + 1, "R5 read latency", busy, E_RD + 1);
        check(rdata == exp_v, "R5 read data", int'(rdata), int'(exp_v));
        got = 1;
      end
      busy++;
      @(negedge clk);
    end
    req = 1'b0;
    if (w) begin
      shadow[int'(a)] = d;
      check(busy - 1 >= E_WC + E_TURN, "R4 write cycle length", busy - 1, E_WC + E_TURN);
      check(rdata == last_rd, "R10 rdata hold", int'(rdata), int'(last_rd));
    end else begin
      check(got, "R5 rvalid seen", int'(got), 1);
      check(busy - 1 == E_RD + E_TURN, "R2 read busy length", busy - 1, E_RD + E_TURN);
      last_rd = exp_v;
    end
  endtask

  task automatic check_idle(input string tag);
    check(ready == 1'b1, tag, int'(ready), 1);
    check(rvalid == 1'b0, tag, int'(rvalid), 0);
    check({cs_n, cs, we_n, oe_n, dq_oe} == 5'b10110, tag,
          int'({cs_n, cs, we_n, oe_n, dq_oe}), 5'b10110);
  endtask

  initial begin
    void'($urandom(32'd7041));
    req = 0; we = 0; addr = '0; wdata = '0; rst_n = 0;
    repeat (5) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_idle("R1 after reset");

    // directed corners
    do_op(1, 18'h00000, 8'h5A);
    do_op(1, 18'h3FFFF, 8'hA5);
    do_op(0, 18'h00000, 8'h00);
    do_op(0, 18'h3FFFF, 8'h00);
    do_op(0, 18'h12345, 8'h00);       // never written
    do_op(1, 18'h12345, 8'hC3);       // write right after read: R7 wait
    do_op(0, 18'h12345, 8'h00);
    do_op(0, 18'h3FFFF, 8'h00);       // read after read
    do_op(1, 18'h3FFFF, 8'h0F);
    do_op(1, 18'h3FFFF, 8'hF0);       // write after write
    do_op(0, 18'h3FFFF, 8'h00);

    // random mix over a small pool
    for (int i = 0; i < 300; i++) begin
      logic [17:0] ra;
      ra = 18'(($urandom % 16) * 16411);
      do_op(1'($urandom), ra, 8'($urandom));
    end

    repeat (4) @(negedge clk);
    check_idle("R1 R8 final idle");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule